// File: doc/BRIEF.md
# AUX Burst Transfer Sequencer

This block accepts a request to read or write a run of bytes in a sink's 20-bit register space and carries it out as a series of native AUX channel transactions. Each transaction moves no more than 16 bytes. For each chunk the sequencer clears a 16-entry byte buffer, loads the target address and a command byte into a lower-level transaction engine, and raises an enable that the engine acknowledges. It then waits for the engine's reply. A chunk that fails is attempted again, up to ten times in all. The address and the data position move forward only after the chunk succeeds.

On the requester side, write bytes are pulled one per cycle from a byte stream, once per chunk. They are held in a staging register, so a retry reloads the same bytes without rewinding the stream. Read bytes are streamed out of the buffer only after the chunk's transaction has succeeded. The requester sees `busy` for the length of the transfer, and then a one-cycle `done` or `error` pulse.

Top module: `aux_burst_seq`

## Requirements
- R1: `busy` is high from the cycle after a request with nonzero length is accepted until the cycle in which `done` or `error` pulses, when it is low. A request presented while `busy` is high has no effect on addresses, commands, data or the outcome.
- R2: Each transaction carries min(remaining length, 16) bytes. The command byte's bits [7:4] hold that count minus one.
- R3: The engine address is presented as `eng_addr_lo` = bits 7:0, `eng_addr_mid` = bits 15:8 and `eng_addr_hi` = bits 19:16. The first chunk uses the request address. Each later chunk uses the previous chunk's address plus its size, modulo 2^20, and the address moves only after a success. Address and command hold steady while `eng_go` is high.
- R4: Command bit 3 is always 1 (native transaction). Bits [2:1] are 0. Bit 0 is 1 for a read and 0 for a write.
- R5: Before every attempt the buffer is cleared. For a write, entries 0..n-1 then hold the chunk's bytes in stream order and the remaining entries are zero when `eng_go` rises. For a read, all entries are zero at that point.
- R6: Read bytes appear on `rd_data` with `rd_valid`, in address order, only after the chunk's transaction has succeeded.
- R7: An attempt fails if `eng_ack` does not arrive while `eng_go` is high, in which case `eng_go` stays high exactly EN_TIMEOUT cycles. It also fails if `eng_reply` does not arrive within RPLY_TIMEOUT cycles after the acknowledge, if `eng_err` is 1 with the reply, or if `eng_status` is nonzero with the reply.
- R8: A chunk is attempted at most 10 times. If the tenth attempt fails, `error` pulses and no further chunk is started.
- R9: `done` pulses for one cycle after the last chunk succeeds. A zero-length request pulses `done` in the cycle after acceptance, with no engine activity. `done` and `error` are never high together.
- R10: For writes, `wr_pull` takes each stream byte exactly once per chunk, regardless of retries. `wr_pull` is never high for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Start address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| wr_pull | output | 1 | Write byte consumed this cycle |
| wr_data | input | 8 | Next write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| eng_addr_lo | output | 8 | Address bits 7:0 |
| eng_addr_mid | output | 8 | Address bits 15:8 |
| eng_addr_hi | output | 4 | Address bits 19:16 |
| eng_cmd | output | 8 | Command byte |
| eng_go | output | 1 | Transaction enable, held until acknowledged |
| eng_ack | input | 1 | Engine took the enable (self-clear) |
| eng_reply | input | 1 | Reply received |
| eng_err | input | 1 | Access error flag, valid with reply |
| eng_status | input | 4 | Reply status, nonzero is failure |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_widx | input | IDX_W | Engine write index |
| eng_buf_wdata | input | 8 | Engine write byte |
| eng_buf_ridx | input | IDX_W | Engine read index |
| eng_buf_rdata | output | 8 | Buffer byte at read index |

## Verification
On every cycle the assertions check the following: `done` and `error` are exclusive, and `busy` is low when either pulses. The address and command hold while the enable is up, the enable never outlasts its timeout, and a clear really empties the buffer. Pulls and read strobes occur only in the matching direction, and the retry counter stays in range. Only the bench's scenarios can show the rest. These are chunk splitting across the 20-bit wrap, the contents of every buffer at each attempt, each of the four failure causes leading to a retry, and the exact reply-timeout gap. They also cover the ten-attempt limit at both edges, the once-per-chunk pulls and the ignored mid-transfer request.

// File: rtl/aux_burst_pkg.sv
package aux_burst_pkg;

    localparam int ADDR_W    = 20;
    localparam int BUF_DEPTH = 16;
    localparam int MAX_TRIES = 10;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [7:0]        byte_t;

    // Command byte sent to the transaction engine
    typedef struct packed {
        logic [3:0] len_m1;   // byte count minus one
        logic       native;   // 1 = native register access, 0 = I2C
        logic [1:0] rsvd;
        logic       rd;       // 1 = read, 0 = write
    } aux_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FETCH,
        ST_PREP,
        ST_ENABLE,
        ST_REPLY,
        ST_DRAIN,
        ST_ADV
    } seq_state_e;

    function automatic aux_cmd_t make_cmd(input logic [4:0] nbytes, input logic is_rd);
        aux_cmd_t c;
        c.len_m1 = 4'(nbytes - 5'd1);
        c.native = 1'b1;
        c.rsvd   = 2'b00;
        c.rd     = is_rd;
        return c;
    endfunction

endpackage

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
    parameter  int LIMIT = 16,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // R7: a waiting phase never runs past its limit
    a_r7_timer_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  ld_en,
    input  logic [DEPTH-1:0][7:0] ld_data,
    input  logic                  eng_we,
    input  logic [IDX_W-1:0]      eng_widx,
    input  logic [7:0]            eng_wdata,
    input  logic [IDX_W-1:0]      eng_ridx,
    output logic [7:0]            eng_rdata,
    input  logic [IDX_W-1:0]      drn_idx,
    output logic [7:0]            drn_data
);

    logic [DEPTH-1:0][7:0] cells;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        logic [7:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)                                    val_q <= '0;
            else if (ld_en)                             val_q <= ld_data[e];
            else if (clr)                               val_q <= '0;
            else if (eng_we && eng_widx == IDX_W'(e))   val_q <= eng_wdata;
        end
        assign cells[e] = val_q;
    end

    assign eng_rdata = cells[eng_ridx];
    assign drn_data  = cells[drn_idx];

    // R5: a clear leaves every entry empty
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !ld_en) |=> (cells == '0));

endmodule

// File: rtl/aux_burst_ctrl.sv
module aux_burst_ctrl
    import aux_burst_pkg::*;
#(
    parameter  int LEN_W  = 12,
    parameter  int DEPTH  = BUF_DEPTH,
    parameter  int TRIES  = MAX_TRIES,
    parameter  int EN_TO  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CL_W   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  addr_t                 req_addr,
    input  logic [LEN_W-1:0]      req_len,
    output logic                  busy,
    output logic                  done,
    output logic                  error,
    output logic                  wr_pull,
    input  logic [7:0]            wr_data,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output addr_t                 eng_addr,
    output aux_cmd_t              eng_cmd,
    output logic                  eng_go,
    input  logic                  eng_ack,
    input  logic                  eng_reply,
    input  logic                  eng_err,
    input  logic [3:0]            eng_status,
    output logic                  buf_clr,
    output logic                  buf_ld,
    output logic [DEPTH-1:0][7:0] stage,
    output logic [IDX_W-1:0]      drain_idx,
    input  logic [7:0]            drain_data,
    output logic                  en_run,
    input  logic                  en_expired,
    output logic                  rp_run,
    input  logic                  rp_expired
);

    localparam int TRY_W = $clog2(TRIES);
    localparam int GO_W  = $clog2(EN_TO + 1);

    seq_state_e            st_q;
    addr_t                 addr_q;
    logic [LEN_W-1:0]      rem_q;
    logic                  rd_q;
    logic [CL_W-1:0]       clen_q;
    logic [IDX_W-1:0]      idx_q;
    logic [TRY_W-1:0]      try_q;
    logic [DEPTH-1:0][7:0] stage_q;
    logic                  done_q;
    logic                  err_q;
    addr_t                 eaddr_q;
    aux_cmd_t              cmd_q;

    logic            reply_bad;
    logic            last_idx;
    logic            attempt_fail;
    logic            final_try;
    logic [CL_W-1:0] clen_next;

    always_comb begin
        reply_bad    = eng_err || (eng_status != 4'd0);
        last_idx     = (idx_q == IDX_W'(clen_q - 1'b1));
        final_try    = (try_q == TRY_W'(TRIES - 1));
        attempt_fail = ((st_q == ST_ENABLE) && !eng_ack && en_expired) ||
                       ((st_q == ST_REPLY) &&
                        ((eng_reply && reply_bad) || (!eng_reply && rp_expired)));
        clen_next    = (rem_q >= LEN_W'(DEPTH)) ? CL_W'(DEPTH) : CL_W'(rem_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            rd_q    <= 1'b0;
            clen_q  <= '0;
            idx_q   <= '0;
            try_q   <= '0;
            stage_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            eaddr_q <= '0;
            cmd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        rem_q  <= req_len;
                        rd_q   <= !req_write;
                        if (req_len == '0) done_q <= 1'b1;
                        else               st_q   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    clen_q  <= clen_next;
                    try_q   <= '0;
                    idx_q   <= '0;
                    stage_q <= '0;
                    st_q    <= rd_q ? ST_PREP : ST_FETCH;
                end
                ST_FETCH: begin
                    stage_q[idx_q] <= wr_data;
                    idx_q          <= idx_q + 1'b1;
                    if (last_idx) st_q <= ST_PREP;
                end
                ST_PREP: begin
                    eaddr_q <= addr_q;
                    cmd_q   <= make_cmd(5'(clen_q), rd_q);
                    st_q    <= ST_ENABLE;
                end
                ST_ENABLE: begin
                    if (eng_ack) st_q <= ST_REPLY;
                end
                ST_REPLY: begin
                    if (eng_reply && !reply_bad) begin
                        idx_q <= '0;
                        st_q  <= rd_q ? ST_DRAIN : ST_ADV;
                    end
                end
                ST_DRAIN: begin
                    idx_q <= idx_q + 1'b1;
                    if (last_idx) st_q <= ST_ADV;
                end
                ST_ADV: begin
                    addr_q <= addr_q + ADDR_W'(clen_q);
                    rem_q  <= rem_q - LEN_W'(clen_q);
                    if (rem_q == LEN_W'(clen_q)) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q   <= ST_SETUP;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase

            if (attempt_fail) begin
                if (final_try) begin
                    err_q <= 1'b1;
                    st_q  <= ST_IDLE;
                end else begin
                    try_q <= try_q + 1'b1;
                    st_q  <= ST_PREP;
                end
            end
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign error     = err_q;
    assign wr_pull   = (st_q == ST_FETCH);
    assign rd_valid  = (st_q == ST_DRAIN);
    assign rd_data   = drain_data;
    assign drain_idx = idx_q;
    assign eng_addr  = eaddr_q;
    assign eng_cmd   = cmd_q;
    assign eng_go    = (st_q == ST_ENABLE);
    assign buf_clr   = (st_q == ST_PREP) && rd_q;
    assign buf_ld    = (st_q == ST_PREP) && !rd_q;
    assign stage     = stage_q;
    assign en_run    = (st_q == ST_ENABLE);
    assign rp_run    = (st_q == ST_REPLY);

    // Independent run-length counter of the enable, for the timeout check
    logic [GO_W-1:0] go_run_q;
    always_ff @(posedge clk) begin
        if (rst)         go_run_q <= '0;
        else if (eng_go) go_run_q <= go_run_q + 1'b1;
        else             go_run_q <= '0;
    end

    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r1_idle_at_end: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);

    a_r7_go_bounded: assert property (@(posedge clk) disable iff (rst)
        eng_go |-> (go_run_q < GO_W'(EN_TO)));

    a_r3_fields_stable: assert property (@(posedge clk) disable iff (rst)
        (eng_go && $past(eng_go)) |-> ($stable(eng_addr) && $stable(eng_cmd)));

    a_r6_read_after_go: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (busy && rd_q && !eng_go));

    a_r10_pull_only_write: assert property (@(posedge clk) disable iff (rst)
        wr_pull |-> (!rd_q && !eng_go));

    a_r8_try_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (try_q < TRY_W'(TRIES)));

endmodule

// File: rtl/aux_burst_seq.sv
module aux_burst_seq
    import aux_burst_pkg::*;
#(
    parameter  int LEN_W        = 12,
    parameter  int DEPTH        = BUF_DEPTH,
    parameter  int TRIES        = MAX_TRIES,
    parameter  int EN_TIMEOUT   = 16,
    parameter  int RPLY_TIMEOUT = 24,
    localparam int IDX_W        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             wr_pull,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [7:0]       eng_addr_lo,
    output logic [7:0]       eng_addr_mid,
    output logic [3:0]       eng_addr_hi,
    output logic [7:0]       eng_cmd,
    output logic             eng_go,
    input  logic             eng_ack,
    input  logic             eng_reply,
    input  logic             eng_err,
    input  logic [3:0]       eng_status,
    input  logic             eng_buf_we,
    input  logic [IDX_W-1:0] eng_buf_widx,
    input  logic [7:0]       eng_buf_wdata,
    input  logic [IDX_W-1:0] eng_buf_ridx,
    output logic [7:0]       eng_buf_rdata
);

    addr_t                 eng_addr;
    aux_cmd_t              cmd;
    logic                  buf_clr;
    logic                  buf_ld;
    logic [DEPTH-1:0][7:0] stage;
    logic [IDX_W-1:0]      drain_idx;
    logic [7:0]            drain_data;
    logic                  en_run;
    logic                  en_expired;
    logic                  rp_run;
    logic                  rp_expired;

    aux_burst_ctrl #(
        .LEN_W (LEN_W),
        .DEPTH (DEPTH),
        .TRIES (TRIES),
        .EN_TO (EN_TIMEOUT)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .busy       (busy),
        .done       (done),
        .error      (error),
        .wr_pull    (wr_pull),
        .wr_data    (wr_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .eng_addr   (eng_addr),
        .eng_cmd    (cmd),
        .eng_go     (eng_go),
        .eng_ack    (eng_ack),
        .eng_reply  (eng_reply),
        .eng_err    (eng_err),
        .eng_status (eng_status),
        .buf_clr    (buf_clr),
        .buf_ld     (buf_ld),
        .stage      (stage),
        .drain_idx  (drain_idx),
        .drain_data (drain_data),
        .en_run     (en_run),
        .en_expired (en_expired),
        .rp_run     (rp_run),
        .rp_expired (rp_expired)
    );

    aux_byte_buf #(
        .DEPTH (DEPTH)
    ) i_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .ld_en     (buf_ld),
        .ld_data   (stage),
        .eng_we    (eng_buf_we),
        .eng_widx  (eng_buf_widx),
        .eng_wdata (eng_buf_wdata),
        .eng_ridx  (eng_buf_ridx),
        .eng_rdata (eng_buf_rdata),
        .drn_idx   (drain_idx),
        .drn_data  (drain_data)
    );

    aux_wait_timer #(.LIMIT(EN_TIMEOUT)) i_en_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (en_run),
        .expired (en_expired)
    );

    aux_wait_timer #(.LIMIT(RPLY_TIMEOUT)) i_rp_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (rp_run),
        .expired (rp_expired)
    );

    assign eng_addr_lo  = eng_addr[7:0];
    assign eng_addr_mid = eng_addr[15:8];
    assign eng_addr_hi  = eng_addr[19:16];
    assign eng_cmd      = cmd;

endmodule

// File: tb/test_aux_burst_seq.sv
`timescale 1ns/1ps
module test_aux_burst_seq;

    localparam int LEN_W  = 12;
    localparam int EN_TO  = 16;
    localparam int RP_TO  = 24;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [19:0] req_addr;
    logic [LEN_W-1:0] req_len;
    logic busy, done, error, wr_pull, rd_valid;
    logic [7:0] wr_data, rd_data;
    logic [7:0] eng_addr_lo, eng_addr_mid, eng_cmd;
    logic [3:0] eng_addr_hi;
    logic eng_go, eng_ack, eng_reply, eng_err;
    logic [3:0] eng_status;
    logic eng_buf_we;
    logic [3:0] eng_buf_widx, eng_buf_ridx;
    logic [7:0] eng_buf_wdata, eng_buf_rdata;

    always #5 clk = ~clk;

    aux_burst_seq #(
        .LEN_W(LEN_W), .DEPTH(16), .TRIES(10),
        .EN_TIMEOUT(EN_TO), .RPLY_TIMEOUT(RP_TO)
    ) i_aux_burst_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .busy(busy), .done(done), .error(error),
        .wr_pull(wr_pull), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_addr_lo(eng_addr_lo), .eng_addr_mid(eng_addr_mid),
        .eng_addr_hi(eng_addr_hi), .eng_cmd(eng_cmd),
        .eng_go(eng_go), .eng_ack(eng_ack), .eng_reply(eng_reply),
        .eng_err(eng_err), .eng_status(eng_status),
        .eng_buf_we(eng_buf_we), .eng_buf_widx(eng_buf_widx),
        .eng_buf_wdata(eng_buf_wdata), .eng_buf_ridx(eng_buf_ridx),
        .eng_buf_rdata(eng_buf_rdata)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sink_byte(input int a);
        int w;
        w = a & 32'hFFFFF;
        return 8'((w * 29 + 7) & 255);
    endfunction

    // Scenario state shared with the responder and stream models
    int plan_in[$];
    int plan_q[$];
    int ea_addr[$];
    int ea_len[$];
    int ea_off[$];
    byte unsigned wq[$];
    byte unsigned got[$];
    int wp;
    bit cur_rd;
    int rs, glen, gap, k, cur_o, cur_len, cur_addr, att_cnt;

    // Write byte stream: one byte per pull
    always @(negedge clk) begin
        wr_data = (wp < wq.size()) ? wq[wp] : 8'h00;
        if (wr_pull) wp++;
    end

    // Read capture
    always @(negedge clk) begin
        if (rd_valid) got.push_back(rd_data);
    end

    // Transaction engine responder
    always @(negedge clk) begin
        eng_ack = 1'b0; eng_reply = 1'b0; eng_err = 1'b0;
        eng_status = 4'd0; eng_buf_we = 1'b0;
        if (rs == 3) begin
            if (eng_go) glen++;
            else begin
                chk(glen == EN_TO, "R7 enable held for timeout", glen, EN_TO);
                rs = 0;
            end
        end else if (rs == 5) begin
            if (!eng_go) gap++;
            else begin
                chk(gap == RP_TO + 1, "R7 reply timeout gap", gap, RP_TO + 1);
                rs = 0;
            end
        end else if (rs == 2) begin
            if (cur_o == 0 && cur_rd && k < cur_len) begin
                eng_buf_we = 1'b1;
                eng_buf_widx = 4'(k);
                eng_buf_wdata = sink_byte(cur_addr + k);
                k++;
            end else if (cur_o == 2) begin
                rs = 5; gap = 1;
            end else begin
                eng_reply = 1'b1;
                eng_err = (cur_o == 3);
                eng_status = (cur_o == 4) ? 4'd3 : 4'd0;
                rs = 0;
            end
        end
        if (rs == 0 && eng_go) begin
            int e_a, e_l, e_o, mism;
            logic [7:0] exp_cmd;
            att_cnt++;
            cur_addr = {12'd0, eng_addr_hi, eng_addr_mid, eng_addr_lo};
            if (ea_addr.size() == 0) begin
                chk(1'b0, "R8 unexpected attempt", att_cnt, 0);
                e_a = cur_addr; e_l = 1; e_o = 0;
            end else begin
                e_a = ea_addr.pop_front(); e_l = ea_len.pop_front(); e_o = ea_off.pop_front();
            end
            chk(cur_addr == e_a, "R3 attempt address", cur_addr, e_a);
            exp_cmd = {4'(e_l - 1), 1'b1, 2'b00, cur_rd};
            chk(eng_cmd[7:4] == exp_cmd[7:4], "R2 chunk length field", int'(eng_cmd[7:4]), int'(exp_cmd[7:4]));
            chk(eng_cmd[3:0] == exp_cmd[3:0], "R4 native and direction bits", int'(eng_cmd[3:0]), int'(exp_cmd[3:0]));
            mism = 0;
            for (int i = 0; i < 16; i++) begin
                logic [7:0] eb;
                eng_buf_ridx = 4'(i);
                #0.2;
                eb = (!cur_rd && i < e_l) ? wq[e_o + i] : 8'h00;
                if (eng_buf_rdata != eb) mism++;
            end
            chk(mism == 0, "R5 buffer contents at attempt", mism, 0);
            cur_o = (plan_q.size() > 0) ? plan_q.pop_front() : 0;
            cur_len = e_l;
            if (cur_o == 1) begin
                rs = 3; glen = 1;
            end else begin
                eng_ack = 1'b1; rs = 2; k = 0;
            end
        end
    end

    task automatic run_case(input int addr, input int len, input bit wr, input bit mid_req);
        int off, cl, exp_pulls, n_exp, busy_bad, mism;
        bit fail, ok;
        int p[$];
        byte unsigned exp_rd[$];
        p = plan_in;
        plan_q = plan_in;
        wq.delete(); got.delete();
        ea_addr.delete(); ea_len.delete(); ea_off.delete();
        for (int j = 0; j < len; j++) wq.push_back(8'((j * 37 + 11 + addr) & 255));
        off = 0; fail = 1'b0; exp_pulls = 0;
        while (off < len && !fail) begin
            cl = (len - off < 16) ? (len - off) : 16;
            if (wr) exp_pulls += cl;
            ok = 1'b0;
            for (int t = 0; t < 10; t++) begin
                int o;
                o = (p.size() > 0) ? p.pop_front() : 0;
                ea_addr.push_back((addr + off) & 32'hFFFFF);
                ea_len.push_back(cl);
                ea_off.push_back(off);
                if (o == 0) begin ok = 1'b1; break; end
            end
            if (!ok) fail = 1'b1;
            else begin
                if (!wr) for (int i = 0; i < cl; i++) exp_rd.push_back(sink_byte(addr + off + i));
                off += cl;
            end
        end
        n_exp = ea_addr.size();
        wp = 0; rs = 0; att_cnt = 0; cur_rd = !wr;
        req_valid = 1'b1; req_write = wr; req_addr = 20'(addr); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (done || error) break;
            if (busy != (len > 0)) busy_bad++;
            if (mid_req && cyc == 40) begin
                req_valid = 1'b1; req_write = !wr; req_addr = 20'h0ABCD; req_len = LEN_W'(3);
            end else req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(busy_bad == 0, "R1 busy held during transfer", busy_bad, 0);
        chk(busy == 1'b0, "R1 busy low at end", int'(busy), 0);
        chk(done == !fail, "R9 done pulse", int'(done), int'(!fail));
        chk(error == fail, "R8 error pulse", int'(error), int'(fail));
        chk(att_cnt == n_exp, "R8 attempt count", att_cnt, n_exp);
        chk(wp == exp_pulls, "R10 write pulls", wp, exp_pulls);
        chk(got.size() == exp_rd.size(), "R6 read byte count", got.size(), exp_rd.size());
        mism = 0;
        for (int i = 0; i < got.size() && i < exp_rd.size(); i++) if (got[i] != exp_rd[i]) mism++;
        chk(mism == 0, "R6 read byte values", mism, 0);
        @(negedge clk);
        chk(!done && !error, "R9 single-cycle pulse", int'(done) + int'(error), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
        eng_ack = 1'b0; eng_reply = 1'b0; eng_err = 1'b0; eng_status = '0;
        eng_buf_we = 1'b0; eng_buf_widx = '0; eng_buf_wdata = '0; eng_buf_ridx = '0;
        wp = 0; rs = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error && !eng_go && !wr_pull && !rd_valid,
            "R1 reset state idle", int'(busy), 0);

        // R2 R4 R5: short write, single chunk
        plan_in = {};
        run_case(32'h12345, 5, 1'b1, 1'b0);
        // R3 R6: read across the 20-bit wrap, chunks 16/16/8
        plan_in = {};
        run_case(32'hFFFF8, 40, 1'b0, 1'b0);
        // R7 R10: every failure cause followed by retries, write 33 bytes
        plan_in = {3, 4, 0, 1, 0, 2, 0};
        run_case(32'h00100, 33, 1'b1, 1'b0);
        // R8: nine failures then success on the tenth attempt
        plan_in = {4, 3, 4, 3, 4, 3, 4, 3, 4, 0};
        run_case(32'h40000, 16, 1'b0, 1'b0);
        // R8: ten reply timeouts on a read ends in error
        plan_in = {2, 2, 2, 2, 2, 2, 2, 2, 2, 2};
        run_case(32'h00200, 16, 1'b0, 1'b0);
        // R8 R10: second chunk of a write fails ten times
        plan_in = {0, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3};
        run_case(32'h00300, 20, 1'b1, 1'b0);
        // R9: zero-length request
        plan_in = {};
        run_case(32'h00400, 0, 1'b1, 1'b0);
        // R1: request during a busy read has no effect
        plan_in = {1, 0};
        run_case(32'h05550, 24, 1'b0, 1'b1);

        finish_run();
    end

endmodule